// File: doc/BRIEF.md
# Management Register Bank with Statistics Counters

This block is the management port of a link-layer core. A host processor reaches it through a simple synchronous bus. The bus has a 10-bit address, a 32-bit write bus, a 32-bit read bus, an active-low select and an active-low write strobe. The lower half of the address space holds a small set of configuration registers. The upper half holds one event counter per address. A 23-bit increment vector feeds the counters, one event per counter per clock. The counters stick at their maximum value instead of wrapping. Reading a counter empties it, so the host must poll often enough to keep counters away from their ceiling.

A board may have no host processor. In that case a static mode input selects a wide configuration-vector input, and that vector loads every configuration register on each clock edge. A status vector always shows the contents of the configuration registers in force, in either mode.

Read data is registered. It appears one clock after the access edge and lasts for exactly that one clock. At all other times the read bus is zero.

Top module: `mgmt_regbank`

## Requirements
- R1: With `hostAbsent` low, a rising edge with `mgmtSelN` and `mgmtWrN` both low writes `mgmtWrData` into the configuration register the address selects. Without such a write the configuration registers hold their value.
- R2: A rising edge with `mgmtSelN` low and `mgmtWrN` high is a read. The addressed value appears on `mgmtRdData` in the following cycle. In any cycle that does not follow a read edge, `mgmtRdData` is zero.
- R3: Address bit 9 clear selects configuration register number `addr[8:0]`, for numbers 0 to NUM_CFG-1 (default 4). Address bit 9 set selects counter number `addr[8:0]`, for numbers 0 to NUM_STATS-1 (default 23). Counter n counts bit n of `statIncr`.
- R4: Each clock edge with `statIncr[n]` high adds one to counter n.
- R5: A counter that holds its all-ones value (2^STAT_W-1) stays there on further events. Counter reads are zero-extended to 32 bits.
- R6: Reading a counter returns its value from before the read edge and clears it at that edge.
- R7: When a counter is read at the same edge as its own increment, it is left holding 1, so the event is kept.
- R8: Writes to counter addresses have no effect. Writes to unmapped addresses have no effect. Reads of unmapped addresses return zero.
- R9: With `hostAbsent` high, at each edge configuration register i loads `cfgVec[32*i+31:32*i]`, and host writes are ignored.
- R10: `cfgStatus[32*i+31:32*i]` always equals configuration register i.
- R11: Synchronous reset clears all configuration registers, all counters and `mgmtRdData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| mgmtAddr | input | 10 | Register address |
| mgmtWrData | input | 32 | Write data from host |
| mgmtSelN | input | 1 | Access select, active low |
| mgmtWrN | input | 1 | Low for write, high for read |
| mgmtRdData | output | 32 | Registered read data, one cycle wide |
| statIncr | input | 23 | Per-counter event pulses |
| hostAbsent | input | 1 | High selects loading from `cfgVec` |
| cfgVec | input | 128 | Configuration source when no host is present |
| cfgStatus | output | 128 | Mirror of the configuration registers |

## Verification
The assertions assume that reset is held for at least one edge before the first access, and that every input is a defined level at each rising edge. The stimulus meets this by driving all inputs only on falling edges, starting from an idle bus under reset.

The stimulus mixes random reads, writes, event vectors and short host-less periods. Its addresses lean toward the mapped ranges but also reach unmapped indices on both halves of the space. Directed runs cover counter saturation, a read colliding with an increment, and writes aimed at the counter half of the space.

// File: rtl/mgmt_regbank_pkg.sv
package mgmt_regbank_pkg;
  // Decoded access strobes passed from control to datapath.
  typedef struct packed {
    logic cfgWr;   // write one configuration register
    logic cfgRd;   // read one configuration register
    logic statRd;  // read (and clear) one counter
  } mgmtStrobes_t;
endpackage

// File: rtl/mgmt_stat_ctr.sv
module mgmt_stat_ctr #(
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              incr,
  input  logic              clr,
  output logic [STAT_W-1:0] count
);
  localparam logic [STAT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (clr) begin
      // read clears; a coincident event seeds the next period
      count <= {{(STAT_W-1){1'b0}}, incr};
    end else if (incr && count != CNT_MAX) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/mgmt_ctrl.sv
module mgmt_ctrl
  import mgmt_regbank_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int NUM_CFG   = 4,
  parameter int NUM_STATS = 23,
  localparam int IDX_W    = ADDR_W - 1
) (
  input  logic              selN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              hostAbsent,
  output mgmtStrobes_t      strobes,
  output logic [IDX_W-1:0]  idx
);
  logic statSpace;
  logic cfgHit;
  logic statHit;
  logic rdAcc;
  logic wrAcc;

  always_comb begin
    statSpace = addr[ADDR_W-1];
    idx       = addr[IDX_W-1:0];
    cfgHit    = !statSpace && (32'(idx) < NUM_CFG);
    statHit   = statSpace && (32'(idx) < NUM_STATS);
    rdAcc     = !selN && wrN;
    wrAcc     = !selN && !wrN;
    strobes.cfgWr  = wrAcc && cfgHit && !hostAbsent;
    strobes.cfgRd  = rdAcc && cfgHit;
    strobes.statRd = rdAcc && statHit;
  end
endmodule

// File: rtl/mgmt_datapath.sv
module mgmt_datapath
  import mgmt_regbank_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int NUM_CFG   = 4,
  parameter int NUM_STATS = 23,
  parameter int STAT_W    = 32,
  localparam int IDX_W    = ADDR_W - 1,
  localparam int CFG_VW   = NUM_CFG * DATA_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  mgmtStrobes_t         strobes,
  input  logic [IDX_W-1:0]     idx,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [NUM_STATS-1:0] statIncr,
  input  logic                 hostAbsent,
  input  logic [CFG_VW-1:0]    cfgVec,
  output logic [DATA_W-1:0]    rdData,
  output logic [CFG_VW-1:0]    cfgStatus
);
  logic [DATA_W-1:0] cfgRegs  [NUM_CFG];
  logic [STAT_W-1:0] statVals [NUM_STATS];
  logic [DATA_W-1:0] rdNext;

  for (genvar g = 0; g < NUM_CFG; g++) begin : gen_cfg
    always_ff @(posedge clk) begin
      if (rst) begin
        cfgRegs[g] <= '0;
      end else if (hostAbsent) begin
        cfgRegs[g] <= cfgVec[g*DATA_W +: DATA_W];
      end else if (strobes.cfgWr && idx == IDX_W'(g)) begin
        cfgRegs[g] <= wrData;
      end
    end
    assign cfgStatus[g*DATA_W +: DATA_W] = cfgRegs[g];
  end

  for (genvar s = 0; s < NUM_STATS; s++) begin : gen_stat
    logic clrHit;
    assign clrHit = strobes.statRd && idx == IDX_W'(s);
    mgmt_stat_ctr #(.STAT_W(STAT_W)) u_ctr (
      .clk   (clk),
      .rst   (rst),
      .incr  (statIncr[s]),
      .clr   (clrHit),
      .count (statVals[s])
    );
  end

  always_comb begin
    rdNext = '0;
    for (int k = 0; k < NUM_CFG; k++) begin
      if (strobes.cfgRd && idx == IDX_W'(k)) rdNext = cfgRegs[k];
    end
    for (int k = 0; k < NUM_STATS; k++) begin
      if (strobes.statRd && idx == IDX_W'(k)) rdNext = DATA_W'(statVals[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdData <= '0;
    else     rdData <= rdNext;
  end
endmodule

// File: rtl/mgmt_regbank.sv
module mgmt_regbank
  import mgmt_regbank_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int NUM_CFG   = 4,
  parameter int NUM_STATS = 23,
  parameter int STAT_W    = 32,
  localparam int IDX_W    = ADDR_W - 1,
  localparam int CFG_VW   = NUM_CFG * DATA_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    mgmtAddr,
  input  logic [DATA_W-1:0]    mgmtWrData,
  input  logic                 mgmtSelN,
  input  logic                 mgmtWrN,
  output logic [DATA_W-1:0]    mgmtRdData,
  input  logic [NUM_STATS-1:0] statIncr,
  input  logic                 hostAbsent,
  input  logic [CFG_VW-1:0]    cfgVec,
  output logic [CFG_VW-1:0]    cfgStatus
);
  mgmtStrobes_t     strobes;
  logic [IDX_W-1:0] idx;

  mgmt_ctrl #(
    .ADDR_W(ADDR_W), .NUM_CFG(NUM_CFG), .NUM_STATS(NUM_STATS)
  ) u_ctrl (
    .selN       (mgmtSelN),
    .wrN        (mgmtWrN),
    .addr       (mgmtAddr),
    .hostAbsent (hostAbsent),
    .strobes    (strobes),
    .idx        (idx)
  );

  mgmt_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CFG(NUM_CFG),
    .NUM_STATS(NUM_STATS), .STAT_W(STAT_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .idx        (idx),
    .wrData     (mgmtWrData),
    .statIncr   (statIncr),
    .hostAbsent (hostAbsent),
    .cfgVec     (cfgVec),
    .rdData     (mgmtRdData),
    .cfgStatus  (cfgStatus)
  );
endmodule

// File: rtl/mgmt_regbank_chk.sv
module mgmt_regbank_chk #(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 32,
  parameter int NUM_CFG = 4,
  parameter int STAT_W  = 32,
  localparam int CFG_VW = NUM_CFG * DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mgmtAddr,
  input logic              mgmtSelN,
  input logic              mgmtWrN,
  input logic [DATA_W-1:0] mgmtRdData,
  input logic              hostAbsent,
  input logic [CFG_VW-1:0] cfgVec,
  input logic [CFG_VW-1:0] cfgStatus
);
  // Read bus is zero unless the previous edge was a read.
  assert_idle_rd_zero_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(mgmtSelN) || !$past(mgmtWrN)) |-> mgmtRdData == '0);

  // Without a write edge or host-less loading, configuration holds.
  assert_cfg_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(hostAbsent) && ($past(mgmtSelN) || $past(mgmtWrN)))
      |-> $stable(cfgStatus));

  // Host-less mode loads the vector on the next edge.
  assert_hostless_load_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(hostAbsent)) |-> cfgStatus == $past(cfgVec));

  // Counter reads never exceed the counter width.
  assert_stat_width_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(mgmtSelN) && $past(mgmtWrN) && $past(mgmtAddr[ADDR_W-1]))
      |-> (mgmtRdData >> STAT_W) == '0);

  // Leaving reset: read bus and configuration are cleared.
  assert_reset_clear_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mgmtRdData == '0 && cfgStatus == '0));
endmodule

bind mgmt_regbank mgmt_regbank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CFG(NUM_CFG), .STAT_W(STAT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mgmtAddr   (mgmtAddr),
  .mgmtSelN   (mgmtSelN),
  .mgmtWrN    (mgmtWrN),
  .mgmtRdData (mgmtRdData),
  .hostAbsent (hostAbsent),
  .cfgVec     (cfgVec),
  .cfgStatus  (cfgStatus)
);

// File: tb/test_mgmt_regbank.sv
module test_mgmt_regbank;
  localparam int NCFG = 4;
  localparam int NST  = 23;
  localparam int SW   = 8;
  localparam int SMAX = 255;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [9:0]   mgmtAddr = '0;
  logic [31:0]  mgmtWrData = '0;
  logic         mgmtSelN = 1'b1;
  logic         mgmtWrN = 1'b1;
  logic [31:0]  mgmtRdData;
  logic [22:0]  statIncr = '0;
  logic         hostAbsent = 1'b0;
  logic [127:0] cfgVec = '0;
  logic [127:0] cfgStatus;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [31:0] cfgModel [NCFG];
  int          cntModel [NST];

  always #10 clk = ~clk;

  mgmt_regbank #(.STAT_W(SW)) i_mgmt_regbank (
    .clk(clk), .rst(rst), .mgmtAddr(mgmtAddr), .mgmtWrData(mgmtWrData),
    .mgmtSelN(mgmtSelN), .mgmtWrN(mgmtWrN), .mgmtRdData(mgmtRdData),
    .statIncr(statIncr), .hostAbsent(hostAbsent), .cfgVec(cfgVec),
    .cfgStatus(cfgStatus)
  );

  task automatic check(input logic [127:0] act, input logic [127:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] readModel(input logic [9:0] a);
    int i = int'(a[8:0]);
    if (!a[9] && i < NCFG) return cfgModel[i];
    if (a[9] && i < NST) return 32'(cntModel[i]);
    return '0;
  endfunction

  function automatic logic [127:0] statusModel();
    return {cfgModel[3], cfgModel[2], cfgModel[1], cfgModel[0]};
  endfunction

  // One bus cycle: drive at falling edge, update model, check after the edge.
  task automatic step(input logic sel, input logic wr, input logic [9:0] a,
                      input logic [31:0] d, input logic [22:0] inc,
                      input logic ha, input logic [127:0] v, input string tag);
    logic [31:0] expRd;
    int i;
    mgmtSelN = sel; mgmtWrN = wr; mgmtAddr = a; mgmtWrData = d;
    statIncr = inc; hostAbsent = ha; cfgVec = v;
    expRd = (!sel && wr) ? readModel(a) : 32'h0;
    i = int'(a[8:0]);
    for (int j = 0; j < NST; j++) begin
      if (!sel && wr && a[9] && i == j) cntModel[j] = inc[j] ? 1 : 0;
      else if (inc[j] && cntModel[j] != SMAX) cntModel[j]++;
    end
    if (ha) begin
      for (int k = 0; k < NCFG; k++) cfgModel[k] = v[32*k +: 32];
    end else if (!sel && !wr && !a[9] && i < NCFG) begin
      cfgModel[i] = d;
    end
    @(posedge clk);
    @(negedge clk);
    check(128'(mgmtRdData), 128'(expRd), tag);
    check(cfgStatus, statusModel(), {tag, " R10 status"});
  endtask

  task automatic idle(input string tag);
    step(1'b1, 1'b1, 10'h0, 32'h0, 23'h0, 1'b0, 128'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL R11 watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    for (int k = 0; k < NCFG; k++) cfgModel[k] = '0;
    for (int j = 0; j < NST; j++) cntModel[j] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11: reset values
    check(128'(mgmtRdData), 128'h0, "R11 rdData after reset");
    check(cfgStatus, 128'h0, "R11 cfgStatus after reset");
    step(1'b0, 1'b1, 10'h205, 32'h0, 23'h0, 1'b0, 128'h0, "R11 counter zero after reset");

    // R1 / R3 / R10: write each configuration register and read back
    for (int k = 0; k < NCFG; k++)
      step(1'b0, 1'b0, 10'(k), 32'hA5A50000 + 32'(k), 23'h0, 1'b0, 128'h0, "R1 cfg write");
    for (int k = 0; k < NCFG; k++)
      step(1'b0, 1'b1, 10'(k), 32'h0, 23'h0, 1'b0, 128'h0, "R3 cfg read");
    idle("R2 read bus returns to zero");

    // R4: counting, then read
    for (int n = 0; n < 5; n++) step(1'b1, 1'b1, 10'h0, 32'h0, 23'h000011, 1'b0, 128'h0, "R4 count");
    step(1'b0, 1'b1, 10'h204, 32'h0, 23'h0, 1'b0, 128'h0, "R4 counter 4 value");
    // R6: cleared by read
    step(1'b0, 1'b1, 10'h204, 32'h0, 23'h0, 1'b0, 128'h0, "R6 cleared after read");
    step(1'b0, 1'b1, 10'h200, 32'h0, 23'h0, 1'b0, 128'h0, "R6 counter 0 value");

    // R5: saturation of counter 3
    for (int n = 0; n < 300; n++) step(1'b1, 1'b1, 10'h0, 32'h0, 23'h000008, 1'b0, 128'h0, "R5 count");
    step(1'b0, 1'b1, 10'h203, 32'h0, 23'h0, 1'b0, 128'h0, "R5 saturated value");
    step(1'b0, 1'b1, 10'h203, 32'h0, 23'h0, 1'b0, 128'h0, "R6 after saturated read");

    // R7: read collides with increment
    step(1'b1, 1'b1, 10'h0, 32'h0, 23'h000080, 1'b0, 128'h0, "R7 pre count");
    step(1'b0, 1'b1, 10'h207, 32'h0, 23'h000080, 1'b0, 128'h0, "R7 read with increment");
    step(1'b0, 1'b1, 10'h207, 32'h0, 23'h0, 1'b0, 128'h0, "R7 event kept");

    // R8: stat writes ignored, unmapped accesses
    step(1'b1, 1'b1, 10'h0, 32'h0, 23'h000004, 1'b0, 128'h0, "R8 pre count");
    step(1'b0, 1'b0, 10'h202, 32'hFFFFFFFF, 23'h0, 1'b0, 128'h0, "R8 write to counter");
    step(1'b0, 1'b1, 10'h202, 32'h0, 23'h0, 1'b0, 128'h0, "R8 counter unchanged");
    step(1'b0, 1'b0, 10'h004, 32'hDEADBEEF, 23'h0, 1'b0, 128'h0, "R8 unmapped write");
    step(1'b0, 1'b1, 10'h1FF, 32'h0, 23'h0, 1'b0, 128'h0, "R8 unmapped cfg read");
    step(1'b0, 1'b1, 10'h3FF, 32'h0, 23'h0, 1'b0, 128'h0, "R8 unmapped stat read");

    // R9: host-less loading, host writes ignored
    step(1'b0, 1'b0, 10'h001, 32'h12345678, 23'h0, 1'b1,
         128'h44444444_33333333_22222222_11111111, "R9 load with host write");
    step(1'b0, 1'b1, 10'h001, 32'h0, 23'h0, 1'b1,
         128'h88888888_77777777_66666666_55555555, "R9 read loaded value");
    idle("R9 leave host-less");

    // Random mix (R2 checks every cycle)
    for (int n = 0; n < 4000; n++) begin
      logic sel, wr, ha;
      logic [9:0] a;
      logic [22:0] inc;
      logic [127:0] v;
      sel = ($urandom_range(9) < 4);
      wr  = ($urandom_range(9) < 7);
      case ($urandom_range(3))
        0: a = {1'b0, 9'($urandom_range(5))};
        1, 2: a = {1'b1, 9'($urandom_range(25))};
        default: a = 10'($urandom);
      endcase
      inc = 23'($urandom) & 23'($urandom);
      ha  = ($urandom_range(19) == 0);
      v   = {$urandom, $urandom, $urandom, $urandom};
      step(sel, wr, a, $urandom, inc, ha, v, "R2 random");
    end

    idle("R2 final idle");
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule